// File: doc/BRIEF.md
# Supply-Pulse Programming Key Decoder

This block decodes a serial programming protocol that arrives entirely on the supply pin. An analog front end outside the block sorts the supply voltage into one of four levels. The block samples that level on a system clock and filters it. It turns the filtered level into a stream of mid and high pulses. It then matches the opening pulses against a table of register-selection keys. Once a register is selected, further mid pulses step a bit-field code. A tester watches a one-clock strobe and takes a measurement each time the code moves.

A key with no extra pulses selects the try mode. If the tester appends eleven mid pulses and then one high pulse, the selection moves to the blow mode. In blow mode a burn request ORs the current code into a sticky fuse mask kept for each register. The code seen at the output is always the counter ORed with the mask of the selected register. A drop to ground acts as a power cycle. It clears the selection, the mode and the counter, but it leaves the fuse masks untouched.

Top module: `spk_decoder`

## Requirements
- R1: After reset, mode_o is 0 (idle), reg_o is 0, code_o is 0 and code_stb_o is 0.
- R2: The level input is coded 0 ground, 1 low, 2 mid, 3 high. A level is accepted only once it has been sampled on FILT consecutive clocks. A shorter excursion, including a short dip to ground, has no effect.
- R3: A pulse is a rise from low to mid or high that later returns to low. Its type is the highest level reached on the way, so a mid step followed by a high step forms one high pulse.
- R4: Key k is the pulse sequence high, mid, then the bits of k from MSB to LSB (1 = high, 0 = mid), then high. When the last pulse of a key falls, mode_o becomes 1 (try), reg_o becomes k and the code becomes 1.
- R5: If the opening pulses from idle match no key, mode_o becomes 3 (fault). A high pulse in a selected mode that does not complete the suffix also gives fault. Fault holds through any further pulses.
- R6: An accepted ground level returns the block to idle from any state, with code_o 0 and reg_o 0.
- R7: For registers NVIRT and above, each mid pulse adds one to the code, and the code saturates at 2^CODE_W-1.
- R8: For even registers below NVIRT, a mid pulse adds one to the code, and a pulse at 2^CODE_W-1 wraps the code to 0.
- R9: For odd registers below NVIRT, a mid pulse subtracts one from the code, and a pulse at 0 wraps the code to 2^CODE_W-1.
- R10: In try mode, a high pulse that comes after exactly eleven mid pulses since selection changes mode_o to 2 (blow) and sets the code back to 1.
- R11: A burn_i cycle in blow mode ORs the code into the selected register's fuse mask. In any other mode burn_i has no effect. Masks survive ground, and code_o shows the code ORed with the mask of reg_o.
- R12: code_stb_o is high for exactly one clock in the cycle the code counter takes a new value. It stays low when a saturated code does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| lvl_i | input | 2 | Classified supply level (0 gnd, 1 low, 2 mid, 3 high) |
| burn_i | input | 1 | Burn request; applies the code to the fuse mask in blow mode |
| reg_o | output | $clog2(NKEYS) | Selected register index |
| mode_o | output | 2 | 0 idle, 1 try, 2 blow, 3 fault |
| code_o | output | CODE_W | Counter ORed with the selected register's fuse mask |
| code_stb_o | output | 1 | One-clock strobe when the counter changes |

## Verification
The bench builds the block with CODE_W of 3 and FILT of 3, and keeps eight keys with four virtual registers. The three-bit code lets a few pulses reach saturation, the up wrap and the down wrap. It also means the eleven-pulse suffix saturates a physical register before the suffix's high pulse switches it to blow mode. A filter depth of three lets a two-clock glitch test R2 against pulses that are only four clocks wide.

// File: rtl/spk_pkg.sv
package spk_pkg;
  localparam logic [1:0] LVL_GND  = 2'd0;
  localparam logic [1:0] LVL_LOW  = 2'd1;
  localparam logic [1:0] LVL_MID  = 2'd2;
  localparam logic [1:0] LVL_HIGH = 2'd3;

  typedef enum logic [1:0] {
    MD_IDLE  = 2'd0,
    MD_TRY   = 2'd1,
    MD_BLOW  = 2'd2,
    MD_FAULT = 2'd3
  } mode_e;

  // Pulses counted since selection before the suffix's high pulse.
  localparam int unsigned SFX_MIDS = 11;

  // One mid-pulse step of the code counter.
  function automatic int unsigned adv_code(int unsigned c, int unsigned top,
                                           logic virt, logic down);
    if (virt && down) return (c == 0) ? top : c - 1;
    if (virt)         return (c == top) ? 0 : c + 1;
    return (c == top) ? top : c + 1;
  endfunction
endpackage

// File: rtl/spk_level_filter.sv
module spk_level_filter #(
  parameter int FILT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] lvl_i,
  output logic [1:0] flt_o
);
  localparam int FW = $clog2(FILT + 1);

  logic [1:0]    cand_q;
  logic [FW-1:0] run_q, run_n;

  always_comb begin
    if (lvl_i != cand_q)           run_n = FW'(1);
    else if (run_q == FW'(FILT))   run_n = run_q;
    else                           run_n = run_q + FW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q <= spk_pkg::LVL_GND;
      run_q  <= FW'(FILT);
      flt_o  <= spk_pkg::LVL_GND;
    end else begin
      cand_q <= lvl_i;
      run_q  <= run_n;
      if (run_n == FW'(FILT)) flt_o <= lvl_i;
    end
  end
endmodule

// File: rtl/spk_pulse_detect.sv
module spk_pulse_detect (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] flt_i,
  output logic       gnd_o,
  output logic       pulse_o,
  output logic       hi_o
);
  import spk_pkg::*;

  logic [1:0] prev_q, peak_q;
  logic       armed_q;

  assign gnd_o   = (flt_i == LVL_GND);
  assign pulse_o = armed_q && (flt_i == LVL_LOW);
  assign hi_o    = (peak_q == LVL_HIGH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= LVL_GND;
      peak_q  <= LVL_LOW;
      armed_q <= 1'b0;
    end else begin
      prev_q <= flt_i;
      if (flt_i == LVL_GND || flt_i == LVL_LOW) begin
        armed_q <= 1'b0;
        peak_q  <= LVL_LOW;
      end else if (prev_q == LVL_LOW) begin
        armed_q <= 1'b1;
        peak_q  <= flt_i;
      end else if (armed_q && flt_i > peak_q) begin
        peak_q <= flt_i;
      end
    end
  end
endmodule

// File: rtl/spk_key_match.sv
module spk_key_match #(
  parameter int NKEYS   = 8,
  parameter int KSEL_W  = 3,
  parameter int KLEN    = 6,
  parameter int KEY_MAX = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic              sym_i,
  output logic              hit_o,
  output logic              miss_o,
  output logic [KSEL_W-1:0] idx_o
);
  localparam int PW = $clog2(KEY_MAX);

  logic [NKEYS-1:0][KEY_MAX-1:0] rom;
  logic [NKEYS-1:0]              alive_q, alive_n;
  logic [PW-1:0]                 pos_q;

  for (genvar k = 0; k < NKEYS; k++) begin : g_key
    localparam logic [KSEL_W-1:0] KB = KSEL_W'(k);
    for (genvar p = 0; p < KEY_MAX; p++) begin : g_sym
      if (p == 0 || p == KLEN - 1) begin : g_hi
        assign rom[k][p] = 1'b1;
      end else if (p == 1 || p >= KLEN) begin : g_lo
        assign rom[k][p] = 1'b0;
      end else begin : g_bit
        assign rom[k][p] = KB[KSEL_W + 1 - p];
      end
    end
  end

  always_comb begin
    for (int k = 0; k < NKEYS; k++)
      alive_n[k] = alive_q[k] && (rom[k][pos_q] == sym_i);
    idx_o = '0;
    for (int k = NKEYS - 1; k >= 0; k--)
      if (alive_n[k]) idx_o = KSEL_W'(k);
  end

  assign miss_o = step_i && (alive_n == '0);
  assign hit_o  = step_i && (alive_n != '0) && (pos_q == PW'(KLEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alive_q <= '1;
      pos_q   <= '0;
    end else if (clr_i || hit_o || miss_o) begin
      alive_q <= '1;
      pos_q   <= '0;
    end else if (step_i) begin
      alive_q <= alive_n;
      pos_q   <= pos_q + PW'(1);
    end
  end
endmodule

// File: rtl/spk_fuse_bank.sv
module spk_fuse_bank #(
  parameter int NKEYS  = 8,
  parameter int KSEL_W = 3,
  parameter int CODE_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_i,
  input  logic [KSEL_W-1:0]       idx_i,
  input  logic [CODE_W-1:0]       bits_i,
  output logic [CODE_W-1:0]       rd_o,
  output logic [NKEYS*CODE_W-1:0] flat_o
);
  logic [NKEYS-1:0][CODE_W-1:0] mask_q;

  assign rd_o   = mask_q[idx_i];
  assign flat_o = mask_q;

  for (genvar k = 0; k < NKEYS; k++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           mask_q[k] <= '0;
      else if (wr_i && idx_i == KSEL_W'(k)) mask_q[k] <= mask_q[k] | bits_i;
    end
  end
endmodule

// File: rtl/spk_decoder.sv
module spk_decoder
  import spk_pkg::*;
#(
  parameter int CODE_W  = 6,
  parameter int FILT    = 4,
  parameter int NKEYS   = 8,
  parameter int KEY_MAX = 8,
  parameter int NVIRT   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 lvl_i,
  input  logic                       burn_i,
  output logic [$clog2(NKEYS)-1:0]   reg_o,
  output logic [1:0]                 mode_o,
  output logic [CODE_W-1:0]          code_o,
  output logic                       code_stb_o
);
  localparam int KSEL_W = $clog2(NKEYS);
  localparam int KLEN   = KSEL_W + 3;
  localparam int unsigned MAXC = (1 << CODE_W) - 1;

  // Named internal events, also observed by the checker.
  logic [1:0]              flt;
  logic                    gnd_evt, pulse_evt, pulse_hi;
  logic                    key_hit, key_miss;
  logic [KSEL_W-1:0]       key_idx;
  logic [CODE_W-1:0]       mask_rd;
  logic [NKEYS*CODE_W-1:0] mask_flat;

  mode_e             mode_q, mode_n;
  logic [KSEL_W-1:0] reg_q, reg_n;
  logic [CODE_W-1:0] code_q, code_n;
  logic [3:0]        mids_q, mids_n;
  logic              stb_q;
  logic              sel, is_virt, burn_ok;

  spk_level_filter #(.FILT(FILT)) u_filt (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl_i), .flt_o(flt)
  );

  spk_pulse_detect u_det (
    .clk(clk), .rst_n(rst_n), .flt_i(flt),
    .gnd_o(gnd_evt), .pulse_o(pulse_evt), .hi_o(pulse_hi)
  );

  spk_key_match #(
    .NKEYS(NKEYS), .KSEL_W(KSEL_W), .KLEN(KLEN), .KEY_MAX(KEY_MAX)
  ) u_keys (
    .clk(clk), .rst_n(rst_n),
    .clr_i(gnd_evt || mode_q != MD_IDLE),
    .step_i(pulse_evt && mode_q == MD_IDLE),
    .sym_i(pulse_hi),
    .hit_o(key_hit), .miss_o(key_miss), .idx_o(key_idx)
  );

  assign burn_ok = burn_i && (mode_q == MD_BLOW);

  spk_fuse_bank #(.NKEYS(NKEYS), .KSEL_W(KSEL_W), .CODE_W(CODE_W)) u_fuse (
    .clk(clk), .rst_n(rst_n), .wr_i(burn_ok), .idx_i(reg_q),
    .bits_i(code_q), .rd_o(mask_rd), .flat_o(mask_flat)
  );

  assign sel     = (mode_q == MD_TRY) || (mode_q == MD_BLOW);
  assign is_virt = (32'(reg_q) < NVIRT);

  always_comb begin
    mode_n = mode_q;
    reg_n  = reg_q;
    code_n = code_q;
    mids_n = mids_q;
    if (gnd_evt) begin
      mode_n = MD_IDLE;
      reg_n  = '0;
      code_n = '0;
      mids_n = '0;
    end else begin
      unique case (mode_q)
        MD_IDLE: begin
          if (key_miss) mode_n = MD_FAULT;
          else if (key_hit) begin
            mode_n = MD_TRY;
            reg_n  = key_idx;
            code_n = CODE_W'(1);
            mids_n = '0;
          end
        end
        MD_TRY, MD_BLOW: begin
          if (pulse_evt && !pulse_hi) begin
            code_n = CODE_W'(adv_code(32'(code_q), MAXC, is_virt, reg_q[0]));
            mids_n = (mids_q == 4'hF) ? mids_q : mids_q + 4'd1;
          end else if (pulse_evt) begin
            if (mode_q == MD_TRY && 32'(mids_q) == SFX_MIDS) begin
              mode_n = MD_BLOW;
              code_n = CODE_W'(1);
              mids_n = '0;
            end else begin
              mode_n = MD_FAULT;
            end
          end
        end
        default: mode_n = MD_FAULT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_IDLE;
      reg_q  <= '0;
      code_q <= '0;
      mids_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      mode_q <= mode_n;
      reg_q  <= reg_n;
      code_q <= code_n;
      mids_q <= mids_n;
      stb_q  <= !gnd_evt && (code_n != code_q);
    end
  end

  assign reg_o      = reg_q;
  assign mode_o     = mode_q;
  assign code_o     = sel ? (code_q | mask_rd) : '0;
  assign code_stb_o = stb_q;
endmodule

// File: rtl/spk_decoder_checker.sv
module spk_decoder_checker #(
  parameter int CODE_W = 6,
  parameter int NKEYS  = 8,
  parameter int KSEL_W = 3,
  parameter int NVIRT  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    gnd_evt,
  input logic                    pulse_evt,
  input logic                    pulse_hi,
  input logic                    key_hit,
  input logic [1:0]              mode_q,
  input logic [KSEL_W-1:0]       reg_q,
  input logic [CODE_W-1:0]       code_q,
  input logic                    code_stb_o,
  input logic [NKEYS*CODE_W-1:0] mask_flat
);
  localparam logic [CODE_W-1:0] TOP = '1;

  assert_stb_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    code_stb_o |=> !code_stb_o);

  assert_ground_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gnd_evt |=> (mode_q == 2'd0 && code_q == '0 && reg_q == '0));

  assert_fault_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd3 && !gnd_evt) |=> (mode_q == 2'd3));

  assert_select_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    key_hit |=> (mode_q == 2'd1 && code_q == CODE_W'(1) && code_stb_o));

  assert_mask_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_flat & $past(mask_flat)) == $past(mask_flat));

  assert_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == 2'd1 || mode_q == 2'd2) && 32'(reg_q) >= NVIRT && pulse_evt
     && !pulse_hi && code_q == TOP && !gnd_evt) |=> (code_q == TOP && !code_stb_o));
endmodule

bind spk_decoder spk_decoder_checker #(
  .CODE_W(CODE_W), .NKEYS(NKEYS), .KSEL_W(KSEL_W), .NVIRT(NVIRT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .gnd_evt(gnd_evt), .pulse_evt(pulse_evt),
  .pulse_hi(pulse_hi), .key_hit(key_hit), .mode_q(mode_q), .reg_q(reg_q),
  .code_q(code_q), .code_stb_o(code_stb_o), .mask_flat(mask_flat)
);

// File: tb/spk_decoder_bench.sv
`timescale 1ns/1ps
module spk_decoder_bench;
  localparam int CW = 3, FL = 3, NK = 8, NV = 4, KS = 3, KL = 6;
  localparam int TOPV = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, burn = 1'b0;
  logic [1:0] lvl = 2'd0;
  logic [KS-1:0] reg_o;
  logic [1:0] mode_o;
  logic [CW-1:0] code_o;
  logic stb_o;

  always #5 clk = ~clk;

  spk_decoder #(.CODE_W(CW), .FILT(FL), .NKEYS(NK), .KEY_MAX(8), .NVIRT(NV)) u_spk_decoder (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .burn_i(burn),
    .reg_o(reg_o), .mode_o(mode_o), .code_o(code_o), .code_stb_o(stb_o)
  );

  int checks = 0, fails = 0, stb_seen = 0;
  bit done = 0;
  string cur_req = "R1";

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int hist[$];
  int m_flt, m_prev, m_peak, m_mode, m_reg, m_code, m_mids, m_stb;
  bit m_armed;
  int syms[$];
  int m_mask[NK];

  function automatic int key_bit(int k, int p);
    if (p == 0 || p == KL - 1) return 1;
    if (p == 1) return 0;
    return (k >> (KL - 2 - p)) & 1;
  endfunction

  function automatic int step(int r, int c);
    if (r < NV && (r % 2) == 1) return (c + TOPV) % (TOPV + 1);
    if (r < NV) return (c + 1) % (TOPV + 1);
    return (c < TOPV) ? c + 1 : TOPV;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist.delete();
      for (int i = 0; i < FL; i++) hist.push_back(0);
      m_flt = 0; m_prev = 0; m_peak = 1; m_armed = 0;
      m_mode = 0; m_reg = 0; m_code = 0; m_mids = 0; m_stb = 0;
      syms.delete();
      foreach (m_mask[i]) m_mask[i] = 0;
    end else begin
      int old_code;
      bit gnd, pev, phi;
      old_code = m_code;
      if (burn && m_mode == 2) m_mask[m_reg] |= m_code;
      gnd = (m_flt == 0);
      pev = m_armed && m_flt == 1;
      phi = (m_peak == 3);
      if (gnd) begin
        m_mode = 0; m_reg = 0; m_code = 0; m_mids = 0; syms.delete();
      end else if (pev) begin
        if (m_mode == 0) begin
          int found;
          found = -1;
          syms.push_back(phi ? 1 : 0);
          for (int k = NK - 1; k >= 0; k--) begin
            bit ok;
            ok = 1;
            foreach (syms[i]) if (syms[i] != key_bit(k, i)) ok = 0;
            if (ok) found = k;
          end
          if (found < 0) begin
            m_mode = 3; syms.delete();
          end else if (syms.size() == KL) begin
            m_mode = 1; m_reg = found; m_code = 1; m_mids = 0; syms.delete();
          end
        end else if (m_mode == 1 || m_mode == 2) begin
          if (!phi) begin
            m_code = step(m_reg, m_code);
            if (m_mids < 15) m_mids++;
          end else if (m_mode == 1 && m_mids == 11) begin
            m_mode = 2; m_code = 1; m_mids = 0;
          end else m_mode = 3;
        end
      end
      m_stb = (!gnd && m_code != old_code) ? 1 : 0;
      // pulse tracking on filtered level
      if (m_flt <= 1) begin
        m_armed = 0; m_peak = 1;
      end else if (m_prev == 1) begin
        m_armed = 1; m_peak = m_flt;
      end else if (m_armed && m_flt > m_peak) m_peak = m_flt;
      m_prev = m_flt;
      // glitch filter: last FL samples all equal
      hist.push_back(int'(lvl));
      void'(hist.pop_front());
      begin
        bit same;
        same = 1;
        foreach (hist[i]) if (hist[i] != hist[0]) same = 0;
        if (same) m_flt = hist[0];
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    int exp_code;
    exp_code = (m_mode == 1 || m_mode == 2) ? (m_code | m_mask[m_reg]) : 0;
    check({cur_req, " model mode"}, int'(mode_o), m_mode);
    check({cur_req, " model reg"}, int'(reg_o), m_reg);
    check({cur_req, " model code"}, int'(code_o), exp_code);
    check({cur_req, " model strobe"}, int'(stb_o), m_stb);
    if (stb_o) stb_seen++;
  end

  task automatic hold(logic [1:0] v, int n);
    lvl = v;
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse(bit hi);
    hold(hi ? 2'd3 : 2'd2, 4);
    hold(2'd1, 5);
  endtask
  task automatic send_key(int k);
    for (int p = 0; p < KL; p++) pulse(key_bit(k, p) == 1);
  endtask
  task automatic mids(int n);
    for (int i = 0; i < n; i++) pulse(0);
  endtask
  task automatic ground();
    hold(2'd0, 5);
    hold(2'd1, 5);
  endtask
  task automatic do_burn();
    burn = 1'b1;
    @(negedge clk);
    burn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(negedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 mode", int'(mode_o), 0);
    check("R1 code", int'(code_o), 0);
    check("R1 reg", int'(reg_o), 0);
    check("R1 strobe", int'(stb_o), 0);

    cur_req = "R2";
    hold(2'd1, 6);
    hold(2'd2, 2);
    hold(2'd1, 6);
    check("R2 short mid ignored", int'(mode_o), 0);

    cur_req = "R4";
    send_key(5);
    check("R4 mode try", int'(mode_o), 1);
    check("R4 reg", int'(reg_o), 5);
    check("R4 code one", int'(code_o), 1);

    cur_req = "R2";
    hold(2'd0, 2);
    hold(2'd1, 6);
    check("R2 short ground ignored", int'(mode_o), 1);

    cur_req = "R7";
    stb_seen = 0;
    mids(8);
    check("R7 saturated", int'(code_o), TOPV);
    check("R12 strobes to saturation", stb_seen, TOPV - 1);

    cur_req = "R5";
    pulse(1);
    check("R5 stray high faults", int'(mode_o), 3);
    pulse(0);
    check("R5 fault holds", int'(mode_o), 3);

    cur_req = "R6";
    ground();
    check("R6 idle", int'(mode_o), 0);
    check("R6 code clear", int'(code_o), 0);

    cur_req = "R9";
    send_key(1);
    pulse(0);
    check("R9 down to zero", int'(code_o), 0);
    pulse(0);
    check("R9 wrap to top", int'(code_o), TOPV);
    ground();

    cur_req = "R8";
    send_key(2);
    mids(6);
    check("R8 reach top", int'(code_o), TOPV);
    pulse(0);
    check("R8 wrap to zero", int'(code_o), 0);
    ground();

    cur_req = "R10";
    send_key(6);
    mids(11);
    pulse(1);
    check("R10 blow mode", int'(mode_o), 2);
    check("R10 code one", int'(code_o), 1);

    cur_req = "R11";
    pulse(0);
    do_burn();
    pulse(0);
    do_burn();
    check("R11 blow code", int'(code_o), 3);
    ground();
    send_key(6);
    check("R11 mask kept", int'(code_o), 3);
    mids(3);
    do_burn();
    check("R11 try code with mask", int'(code_o), 7);
    ground();
    send_key(6);
    check("R11 burn in try ignored", int'(code_o), 3);
    ground();
    send_key(7);
    check("R11 mask per register", int'(code_o), 1);
    ground();

    cur_req = "R5";
    pulse(0);
    check("R5 bad key", int'(mode_o), 3);
    ground();

    cur_req = "R3";
    hold(2'd2, 4);
    hold(2'd3, 4);
    hold(2'd1, 5);
    for (int p = 1; p < KL; p++) pulse(key_bit(4, p) == 1);
    check("R3 mixed pulse is high", int'(mode_o), 1);
    check("R3 reg", int'(reg_o), 4);

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule